// File: doc/BRIEF.md
# Vector Element Store Lane Aligner

This block sits between the vector register file and a 32-bit, byte-addressed memory port. For each indexed access it forms the effective address from a base and an index operand, then aligns that address to the size of the access. It maps the 128-bit register onto the 16-byte memory block that holds the address and sends the result out as one or more 32-bit beats, each with its own byte enables. The same byte mapping runs the other way for whole-vector loads: the beats that come back are assembled into a 128-bit register value.

The accesses are whole-vector stores, whole-vector loads, and single-element stores of a byte, halfword or word. Each can run in big-endian or little-endian mode. Variants that only carry a cache hint are decoded upstream onto the same requests, so the block never sees the hint.

The controller is a three-state machine:
- `S_IDLE` accepts a request (the transition `S_IDLE -> S_XFER` happens on `req_valid`).
- `S_XFER` issues beats. It stays in `S_XFER` while beats remain or `mem_ready` is low. It goes `S_XFER -> S_IDLE` after the final beat of a store, and `S_XFER -> S_RESP` after the final beat of a load.
- `S_RESP` presents the load result for one cycle and always returns `S_RESP -> S_IDLE`.

Reset forces `S_IDLE` from any state.

Top module: `vec_lane_aligner`

## Requirements
- R1: The effective address is `req_index` plus either `req_base`, or zero when `req_base_zero` is 1, modulo 2^32. It is then aligned by `req_size`: 0 = byte (no bits cleared), 1 = halfword (bit 0 cleared), 2 = word (bits 1:0 cleared), 3 = vector (bits 3:0 cleared). Every beat address is word aligned: `mem_addr` = aligned address with bits 1:0 cleared, plus 4 times the beat number within the block.
- R2: `req_ready` is 1 only in `S_IDLE`; a request is taken when `req_valid` and `req_ready` are both 1. While a transfer or load result is pending, `req_ready` is 0.
- R3: An element store (size 0, 1 or 2 with `req_load` = 0) issues exactly one beat with `mem_we` = 1. That beat goes to the word that contains the aligned address, and its `mem_be` covers exactly 1, 2 or 4 bytes starting at the aligned address.
- R4: Memory byte m of the 16-byte block (m = address bits 3:0) takes register byte m in big-endian mode (`req_le` = 0) and register byte 15-m in little-endian mode. Register byte 0 is `req_vec[127:120]`. Within a beat, memory byte address `mem_addr`+k travels on `mem_wdata[8k+7:8k]`.
- R5: A vector store issues four beats with `mem_be` = 4'b1111, at block offsets 0, 4, 8 and 12 in that order.
- R6: While `mem_valid` is 1 and `mem_ready` is 0, the next cycle keeps `mem_valid` at 1 and leaves `mem_addr`, `mem_be`, `mem_we` and `mem_wdata` unchanged.
- R7: A vector load (`req_load` = 1) issues four beats with `mem_we` = 0 at offsets 0, 4, 8 and 12. The cycle after the final beat is accepted, `ld_valid` is 1 for exactly one cycle. `ld_data` register byte m then equals memory byte m (big-endian) or memory byte 15-m (little-endian), using the byte-lane convention of R4 for `mem_rdata`.
- R8: A load ignores `req_size`: it always aligns to 16 bytes and transfers the whole vector.
- R9: While reset is asserted, whatever the state, `req_ready` = 1, `mem_valid` = 0 and `ld_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_base | input | 32 | Base operand |
| req_index | input | 32 | Index operand |
| req_base_zero | input | 1 | Treat the base as zero |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 vector |
| req_load | input | 1 | 1 = whole-vector load, 0 = store |
| req_le | input | 1 | 1 = little-endian mode |
| req_vec | input | 128 | Source vector for stores |
| mem_valid | output | 1 | Beat present on the memory port |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 32 | Word-aligned beat address |
| mem_be | output | 4 | Byte enables of the beat |
| mem_wdata | output | 32 | Write data of the beat |
| mem_rdata | input | 32 | Read data, valid with an accepted read beat |
| ld_valid | output | 1 | Load result present (one cycle) |
| ld_data | output | 128 | Assembled load result |

## Verification
Three internal faults are visible at the ports:
- A beat counter that skips or repeats shows up as a wrong `mem_addr` on the very next beat, or as a wrong beat count by the end of the transfer.
- A lane mirror that is applied in the wrong mode corrupts enabled write bytes in the first beat, or corrupts `ld_data` one cycle after the last read beat.
- A state machine that leaves `S_XFER` early or late changes the beat count. It also moves the `ld_valid` pulse away from the cycle after the final accepted read beat. A stall that is not held shows up one cycle later as a changed address or data.

// File: rtl/vla_pkg.sv
package vla_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_VEC  = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_XFER = 2'd1,
        S_RESP = 2'd2
    } xfer_state_e;

endpackage

// File: rtl/vla_agu.sv
// Effective address generation and alignment by access size.
module vla_agu
    import vla_pkg::*;
#(
    parameter int AW   = 32,
    parameter int BLKB = 16
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] index,
    input  logic          base_zero,
    input  acc_size_e     size,
    output logic [AW-1:0] ea
);
    localparam int BLKW = $clog2(BLKB);

    logic [AW-1:0] sum;
    logic [AW-1:0] mask;

    always_comb begin
        sum = (base_zero ? '0 : base) + index;
        unique case (size)
            SZ_BYTE: mask = '1;
            SZ_HALF: mask = ~AW'(1);
            SZ_WORD: mask = ~AW'(3);
            SZ_VEC:  mask = ~AW'((1 << BLKW) - 1);
        endcase
        ea = sum & mask;
    end
endmodule

// File: rtl/vla_byte_en.sv
// Byte enables across the whole block: contiguous run of the access size.
module vla_byte_en
    import vla_pkg::*;
#(
    parameter int NB = 16
) (
    input  acc_size_e              size,
    input  logic [$clog2(NB)-1:0]  off,
    output logic [NB-1:0]          be
);
    localparam int OW = $clog2(NB);
    localparam int LW = OW + 2;

    logic [LW-1:0] len;
    logic [LW-1:0] lo;
    logic [LW-1:0] hi;

    always_comb begin
        unique case (size)
            SZ_BYTE: len = LW'(1);
            SZ_HALF: len = LW'(2);
            SZ_WORD: len = LW'(4);
            SZ_VEC:  len = LW'(NB);
        endcase
        lo = LW'(off);
        hi = lo + len;
    end

    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign be[i] = (LW'(i) >= lo) && (LW'(i) < hi);
    end
endmodule

// File: rtl/vla_lane_mirror.sv
// Maps register byte order (byte 0 in the top bits) to memory byte order
// (byte 0 in the low bits), honouring the endian mode. The map is its own
// inverse, so one instance serves stores and another serves loads.
module vla_lane_mirror #(
    parameter int NB = 16
) (
    input  logic            le,
    input  logic [NB*8-1:0] din,
    output logic [NB*8-1:0] dout
);
    for (genvar i = 0; i < NB; i++) begin : g_byte
        assign dout[8*i +: 8] = le ? din[8*i +: 8] : din[8*(NB-1-i) +: 8];
    end
endmodule

// File: rtl/vec_lane_aligner.sv
module vec_lane_aligner
    import vla_pkg::*;
#(
    parameter int AW = 32,
    parameter int VW = 128,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_base,
    input  logic [AW-1:0] req_index,
    input  logic          req_base_zero,
    input  logic [1:0]    req_size,
    input  logic          req_load,
    input  logic          req_le,
    input  logic [VW-1:0] req_vec,
    output logic          mem_valid,
    input  logic          mem_ready,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW/8-1:0] mem_be,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          ld_valid,
    output logic [VW-1:0] ld_data
);
    localparam int NB    = VW / 8;
    localparam int BB    = DW / 8;
    localparam int NBEAT = VW / DW;
    localparam int BLKW  = $clog2(NB);
    localparam int OFFW  = $clog2(BB);
    localparam int BTW   = $clog2(NBEAT);

    // ---------------- request decode ----------------
    acc_size_e     eff_size;
    logic [AW-1:0] ea;
    logic [NB-1:0] be_all;
    logic [VW-1:0] st_img;
    logic          is_vec;
    logic [BTW-1:0] first_beat;

    always_comb begin
        eff_size   = req_load ? SZ_VEC : acc_size_e'(req_size);
        is_vec     = (eff_size == SZ_VEC);
        first_beat = is_vec ? '0 : ea[BLKW-1:OFFW];
    end

    vla_agu #(.AW(AW), .BLKB(NB)) u_agu (
        .base      (req_base),
        .index     (req_index),
        .base_zero (req_base_zero),
        .size      (eff_size),
        .ea        (ea)
    );

    vla_byte_en #(.NB(NB)) u_be (
        .size (eff_size),
        .off  (ea[BLKW-1:0]),
        .be   (be_all)
    );

    vla_lane_mirror #(.NB(NB)) u_st_mirror (
        .le   (req_le),
        .din  (req_vec),
        .dout (st_img)
    );

    // ---------------- state and datapath registers ----------------
    xfer_state_e state_q, state_d;

    logic [AW-BLKW-1:0]            blk_q;
    logic [BTW-1:0]                beat_q;
    logic [BTW-1:0]                last_q;
    logic                          we_q;
    logic                          le_q;
    logic [NBEAT-1:0][BB-1:0]      be_q;
    logic [NBEAT-1:0][DW-1:0]      img_q;
    logic                          accept;
    logic                          beat_done;
    logic                          final_beat;

    assign accept     = (state_q == S_IDLE) && req_valid;
    assign beat_done  = (state_q == S_XFER) && mem_ready;
    assign final_beat = (beat_q == last_q);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (req_valid) state_d = S_XFER;
            S_XFER: if (mem_ready && final_beat) state_d = we_q ? S_IDLE : S_RESP;
            S_RESP: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_q  <= '0;
            beat_q <= '0;
            last_q <= '0;
            we_q   <= 1'b0;
            le_q   <= 1'b0;
            be_q   <= '0;
            img_q  <= '0;
        end else if (accept) begin
            blk_q  <= ea[AW-1:BLKW];
            beat_q <= first_beat;
            last_q <= is_vec ? BTW'(NBEAT - 1) : first_beat;
            we_q   <= !req_load;
            le_q   <= req_le;
            be_q   <= be_all;
            img_q  <= st_img;
        end else if (beat_done) begin
            if (!we_q) img_q[beat_q] <= mem_rdata;
            if (!final_beat) beat_q <= beat_q + BTW'(1);
        end
    end

    // output logic
    always_comb begin
        req_ready = 1'b0;
        mem_valid = 1'b0;
        ld_valid  = 1'b0;
        unique case (state_q)
            S_IDLE: req_ready = 1'b1;
            S_XFER: mem_valid = 1'b1;
            S_RESP: ld_valid  = 1'b1;
            default: req_ready = 1'b0;
        endcase
        mem_we    = mem_valid && we_q;
        mem_addr  = {blk_q, beat_q, {OFFW{1'b0}}};
        mem_be    = mem_valid ? be_q[beat_q] : '0;
        mem_wdata = img_q[beat_q];
    end

    vla_lane_mirror #(.NB(NB)) u_ld_mirror (
        .le   (le_q),
        .din  (img_q),
        .dout (ld_data)
    );

    // ---------------- assertions ----------------
    a_r2_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_valid && !ld_valid));

    a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_be)
                                       && $stable(mem_we) && $stable(mem_wdata)));

    a_r5_beat_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && !final_beat) |=>
            (mem_valid && mem_addr == $past(mem_addr) + AW'(BB)));

    a_r7_result_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(mem_valid && mem_ready && !mem_we));

    a_r3_be_width: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2
                       || $countones(mem_be) == 4));

    a_r7_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> !ld_valid);
endmodule

// File: tb/tb_vec_lane_aligner.sv
`timescale 1ns/1ps
module tb_vec_lane_aligner;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [31:0]   req_base = '0;
    logic [31:0]   req_index = '0;
    logic          req_base_zero = 1'b0;
    logic [1:0]    req_size = '0;
    logic          req_load = 1'b0;
    logic          req_le = 1'b0;
    logic [127:0]  req_vec = '0;
    logic          mem_valid;
    logic          mem_ready = 1'b0;
    logic          mem_we;
    logic [31:0]   mem_addr;
    logic [3:0]    mem_be;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata;
    logic          ld_valid;
    logic [127:0]  ld_data;

    always #2.5 clk = ~clk;

    vec_lane_aligner dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_base(req_base), .req_index(req_index), .req_base_zero(req_base_zero),
        .req_size(req_size), .req_load(req_load), .req_le(req_le), .req_vec(req_vec),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .ld_valid(ld_valid), .ld_data(ld_data)
    );

    // read memory: word returned for each beat position in the block
    logic [31:0] rd_word [4];
    assign mem_rdata = rd_word[mem_addr[3:2]];

    // register byte i = i*0x11
    localparam logic [127:0] SRC = 128'h00112233_44556677_8899AABB_CCDDEEFF;

    typedef struct packed {
        logic [31:0] base;
        logic [31:0] idx;
        logic        bz;
        logic [1:0]  sz;
        logic        le;
        logic [31:0] addr;
        logic [3:0]  be;
        logic [31:0] wd;
    } ent_t;

    localparam int NT = 9;
    localparam ent_t TBL [NT] = '{
        '{32'h0000_0100, 32'h5,  1'b0, 2'd0, 1'b0, 32'h104,  4'b0010, 32'h0000_5500},
        '{32'h0000_0100, 32'h5,  1'b0, 2'd0, 1'b1, 32'h104,  4'b0010, 32'h0000_AA00},
        '{32'h0000_0100, 32'hF,  1'b1, 2'd0, 1'b0, 32'h00C,  4'b1000, 32'hFF00_0000},
        '{32'h0000_0200, 32'h7,  1'b0, 2'd1, 1'b0, 32'h204,  4'b1100, 32'h7766_0000},
        '{32'h0000_0200, 32'h7,  1'b0, 2'd1, 1'b1, 32'h204,  4'b1100, 32'h8899_0000},
        '{32'h0000_1000, 32'h1B, 1'b0, 2'd2, 1'b0, 32'h1018, 4'b1111, 32'hBBAA_9988},
        '{32'h0000_1000, 32'h1B, 1'b0, 2'd2, 1'b1, 32'h1018, 4'b1111, 32'h4455_6677},
        '{32'h0000_FFFF, 32'h1,  1'b1, 2'd1, 1'b0, 32'h000,  4'b0011, 32'h0000_1100},
        '{32'hFFFF_FFFF, 32'h1,  1'b0, 2'd0, 1'b1, 32'h000,  4'b0001, 32'h0000_00FF}
    };

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-run capture
    int          nb;
    int          ldn;
    logic [31:0] ca [4];
    logic [3:0]  cb [4];
    logic [31:0] cw [4];
    logic [127:0] ldc;
    bit          any_we;
    bit          r2_ok;
    bit          r6_ok;

    task automatic run(input logic [31:0] base, input logic [31:0] idx, input bit bz,
                       input logic [1:0] sz, input bit ld, input bit le, input bit stall);
        logic [31:0] paddr;
        logic [31:0] pwd;
        bit          hold;
        nb = 0; ldn = 0; any_we = 0; r2_ok = 1; r6_ok = 1; hold = 0;
        paddr = '0; pwd = '0; ldc = '0;
        @(negedge clk);
        req_base = base; req_index = idx; req_base_zero = bz; req_size = sz;
        req_load = ld; req_le = le; req_vec = SRC; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int cyc = 0; cyc < 60; cyc++) begin
            if (hold && (!mem_valid || mem_addr != paddr || mem_wdata != pwd)) r6_ok = 0;
            hold = 0;
            if (ld_valid) begin ldn++; ldc = ld_data; end
            if (mem_valid) begin
                if (req_ready) r2_ok = 0;
                if (mem_we) any_we = 1;
                if (stall && (cyc % 2 == 0)) begin
                    mem_ready = 1'b0; hold = 1; paddr = mem_addr; pwd = mem_wdata;
                end else begin
                    mem_ready = 1'b1;
                    if (nb < 4) begin ca[nb] = mem_addr; cb[nb] = mem_be; cw[nb] = mem_wdata; end
                    nb++;
                end
            end else begin
                mem_ready = 1'b0;
                if (req_ready) break;
            end
            @(negedge clk);
        end
        mem_ready = 1'b0;
    endtask

    function automatic logic [31:0] lane_mask(input logic [3:0] be);
        for (int k = 0; k < 4; k++) lane_mask[8*k +: 8] = {8{be[k]}};
    endfunction

    // watchdog
    initial begin
        #500000;
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R9: reset state
        rd_word[0] = 32'h3322_1100; rd_word[1] = 32'h7766_5544;
        rd_word[2] = 32'hBBAA_9988; rd_word[3] = 32'hFFEE_DDCC;
        repeat (3) @(negedge clk);
        chk(req_ready && !mem_valid && !ld_valid, "R9 reset outputs",
            {req_ready, mem_valid, ld_valid}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);

        // element stores from the table: R1 R3 R4
        for (int t = 0; t < NT; t++) begin
            run(TBL[t].base, TBL[t].idx, TBL[t].bz, TBL[t].sz, 1'b0, TBL[t].le, t[0]);
            chk(nb == 1, "R3 one beat", nb, 1);
            chk(ca[0] == TBL[t].addr, "R1 beat address", ca[0], TBL[t].addr);
            chk(cb[0] == TBL[t].be, "R3 byte enables", cb[0], TBL[t].be);
            chk((cw[0] & lane_mask(TBL[t].be)) == TBL[t].wd, "R4 lane data",
                cw[0] & lane_mask(TBL[t].be), TBL[t].wd);
            chk(r2_ok && r6_ok && any_we, "R2/R6 handshake", {r2_ok, r6_ok, any_we}, 3'b111);
        end

        // R5 R4 R6: vector store big-endian with stalls
        run(32'h3000, 32'h1D, 1'b0, 2'd3, 1'b0, 1'b0, 1'b1);
        chk(nb == 4, "R5 four beats", nb, 4);
        chk(r6_ok, "R6 stall hold", r6_ok, 1);
        chk(r2_ok, "R2 busy not ready", r2_ok, 1);
        for (int k = 0; k < 4; k++) begin
            chk(ca[k] == 32'h3010 + 32'(4 * k), "R5 beat order", ca[k], 32'h3010 + 32'(4 * k));
            chk(cb[k] == 4'hF, "R5 full enables", cb[k], 4'hF);
        end
        chk(cw[0] == 32'h3322_1100 && cw[3] == 32'hFFEE_DDCC, "R4 big-endian vector",
            {cw[0], cw[3]}, {32'h3322_1100, 32'hFFEE_DDCC});

        // R4: vector store little-endian
        run(32'h40, 32'h0, 1'b1, 2'd3, 1'b0, 1'b1, 1'b0);
        chk(nb == 4 && ca[0] == 32'h0, "R5 LE beats", {nb, ca[0]}, {32'd4, 32'h0});
        chk(cw[0] == 32'hCCDD_EEFF && cw[1] == 32'h8899_AABB &&
            cw[2] == 32'h4455_6677 && cw[3] == 32'h0011_2233, "R4 little-endian vector",
            {cw[0], cw[1], cw[2], cw[3]},
            {32'hCCDD_EEFF, 32'h8899_AABB, 32'h4455_6677, 32'h0011_2233});

        // R7: vector load big-endian
        run(32'h500, 32'h7, 1'b0, 2'd3, 1'b1, 1'b0, 1'b0);
        chk(nb == 4 && !any_we, "R7 four read beats", {nb, any_we}, {32'd4, 1'b0});
        chk(ca[0] == 32'h500 && ca[3] == 32'h50C, "R7 read addresses",
            {ca[0], ca[3]}, {32'h500, 32'h50C});
        chk(ldn == 1, "R7 single result pulse", ldn, 1);
        chk(ldc == SRC, "R7 big-endian assembly", ldc, SRC);

        // R8: load with byte size, little-endian, stalled
        run(32'h600, 32'h9, 1'b0, 2'd0, 1'b1, 1'b1, 1'b1);
        chk(nb == 4 && ca[0] == 32'h600, "R8 load whole vector", {nb, ca[0]}, {32'd4, 32'h600});
        chk(ldn == 1, "R7 LE result pulse", ldn, 1);
        chk(ldc == 128'hFFEEDDCC_BBAA9988_77665544_33221100, "R7 little-endian assembly",
            ldc, 128'hFFEEDDCC_BBAA9988_77665544_33221100);

        // R9: reset in the middle of a transfer
        @(negedge clk);
        req_base = 32'h800; req_index = 0; req_base_zero = 0; req_size = 2'd3;
        req_load = 0; req_le = 0; req_valid = 1'b1; mem_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk(mem_valid && !req_ready, "R2 busy while stalled", {mem_valid, req_ready}, 2'b10);
        rst_n = 1'b0;
        @(negedge clk);
        chk(req_ready && !mem_valid && !ld_valid, "R9 reset mid transfer",
            {req_ready, mem_valid, ld_valid}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);

        // after reset the block works again
        run(32'h0, 32'h3, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
        chk(nb == 1 && ca[0] == 32'h0 && cb[0] == 4'b1000, "R3 after reset",
            {nb, ca[0], cb[0]}, {32'd1, 32'h0, 4'b1000});

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule